// File: doc/BRIEF.md
# Configuration Read Retry Engine

This block runs one configuration read toward a downstream PCIe device at a time and hides two awkward behaviours of the link glue from the requester. The glue cannot tell an unsupported-request completion from a not-ready completion. So when the identifier dword (dword-aligned offset 0) of function 0 reads back as all zeros or all ones, the engine treats the device as possibly still starting up. It waits a set number of millisecond ticks and tries again. After a bounded number of retries it gives up and reports the device as not found.

A read that ends in a bus error or abort is never passed on as a fault. Its data is replaced by all ones, and it is then judged like any other returned value.

Each attempt has three steps, always in the same order. First the engine writes the target bus/device/function value to the glue. Then it completes a flush read-back of that value. Only then does it issue the configuration read. Both the request side and the response side use valid/ready handshakes:
- A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the engine is idle.
- Each downstream step (`bdf_*`, `flush_*`, `rd_*`) holds its valid high, with a stable payload, until the matching ready is seen.
- The response holds `rsp_valid`, `rsp_data` and `rsp_not_found` stable until `rsp_ready` is high. A stalled response therefore blocks the next request.
- The completion input has no ready. It is taken only while the engine waits for a read result, and it is ignored at any other time.

Top module: `cfg_probe_retry`

## Requirements
- R1: A completion is a retry candidate only when `req_offset[11:2]` is zero, `req_devfn` is 8'h00, and the effective data is 32'h00000000 or 32'hFFFFFFFF. Bits [1:0] of the offset play no part in this test.
- R2: After a retry candidate, `bdf_valid` for the next attempt rises in the cycle after the GAP_TICKS-th `ms_tick` sampled since that completion was taken.
- R3: At most MAX_RETRY retries are made, so there are at most MAX_RETRY+1 reads. If the last read is still a candidate, the response is 32'hFFFFFFFF with `rsp_not_found` = 1.
- R4: A completion with `cpl_err` = 1 is treated as data 32'hFFFFFFFF and raises no fault. `rsp_not_found` is set only when the engine gives up.
- R5: Every attempt performs the BDF write, then the flush, then the read, in that order. `bdf_value` = {bus, devfn} and `rd_dwaddr` = `req_offset[11:2]`.
- R6: A completion that is not a retry candidate ends the request at once. The response carries the effective data, with `rsp_not_found` = 0.
- R7: `req_ready` is high only while the engine is idle. `done` is high for exactly the cycle in which the response handshake takes place.
- R8: The retry count and the tick-gap count restart from zero for every accepted request.
- R9: Every output valid, once raised, stays high with a stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Register byte offset |
| bdf_valid | output | 1 | BDF register write request |
| bdf_ready | input | 1 | BDF write accepted |
| bdf_value | output | 16 | {bus, devfn} to program |
| flush_valid | output | 1 | BDF read-back request |
| flush_ready | input | 1 | Read-back complete |
| rd_valid | output | 1 | Configuration read request |
| rd_ready | input | 1 | Read request accepted |
| rd_dwaddr | output | 10 | Dword address of the register |
| cpl_valid | input | 1 | Read completion present |
| cpl_data | input | 32 | Completion data |
| cpl_err | input | 1 | Bus error / abort on the read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | 32 | Returned data |
| rsp_not_found | output | 1 | Device declared absent |
| done | output | 1 | Request finished this cycle |

## Verification
The chain of timings is as follows:
- `bdf_valid` rises in the cycle after a request is accepted.
- Each later step (flush, read) goes valid in the cycle after the handshake before it.
- The response, or the wait for ticks, begins in the cycle after the completion is taken.
- A retry's BDF write appears in the cycle after the GAP_TICKS-th tick.

The bench sets its ready levels and its tick and completion pulses on the falling edge. It then observes every handshake shortly after that edge, so each one it records is the one the next rising edge will commit. A behavioural model built from the completion script predicts the exact ordered list of handshakes and the final response. The bench compares that list on every clock, and also checks the tick count seen before each retry.

// File: rtl/cfgrr_pkg.sv
package cfgrr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BDF,
    ST_FLUSH,
    ST_RD,
    ST_WAIT,
    ST_GAP,
    ST_RSP
  } cfgrr_state_t;

  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
endpackage

// File: rtl/cfgrr_qualify.sv
module cfgrr_qualify
  import cfgrr_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int FN_W  = 8
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [FN_W-1:0]   devfn,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              raw_err,
  output logic [DATA_W-1:0] eff_data,
  output logic              retry_hit
);
  localparam int DW_W = OFF_W - 2;

  logic id_dword;
  logic fn_zero;
  logic suspect;

  // R4: an aborted read reads as all ones
  assign eff_data  = raw_err ? ALL_ONES : raw_data;
  assign id_dword  = (offset[OFF_W-1:2] == '0);
  assign fn_zero   = (devfn == '0);
  assign suspect   = (eff_data == '0) || (eff_data == ALL_ONES);
  assign retry_hit = id_dword && fn_zero && suspect;   // R1

  initial begin
    if (DW_W < 1) $error("offset width too small");
  end
endmodule

// File: rtl/cfgrr_pacer.sv
module cfgrr_pacer #(
  parameter int MAX_RETRY = 1000,
  parameter int GAP_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  input  logic tick_en,
  output logic exhausted,
  output logic gap_done
);
  localparam int CW = $clog2(MAX_RETRY + 2);
  localparam int GW = $clog2(GAP_TICKS + 1);

  logic [CW-1:0] retries;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    retries <= '0;
    else if (clr)  retries <= '0;
    else if (bump) retries <= retries + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '0;
    else if (clr || bump) gap <= '0;
    else if (tick_en)     gap <= gap_done ? '0 : gap + 1'b1;
  end

  assign exhausted = (retries == CW'(MAX_RETRY));
  assign gap_done  = tick_en && (gap == GW'(GAP_TICKS - 1));

  a_r3_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    retries <= CW'(MAX_RETRY));
  a_r3_no_bump_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !bump);
  a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (retries == '0) && (gap == '0));
  a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GW'(GAP_TICKS));
endmodule

// File: rtl/cfgrr_seq.sv
module cfgrr_seq
  import cfgrr_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int FN_W  = 8,
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [FN_W-1:0]    req_devfn,
  input  logic [OFF_W-1:0]   req_offset,
  output logic               bdf_valid,
  input  logic               bdf_ready,
  output logic [BUS_W+FN_W-1:0] bdf_value,
  output logic               flush_valid,
  input  logic               flush_ready,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [OFF_W-3:0]   rd_dwaddr,
  input  logic               cpl_valid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_not_found,
  output logic               done,
  output logic [FN_W-1:0]    cur_devfn,
  output logic [OFF_W-1:0]   cur_offset,
  input  logic [DATA_W-1:0]  eff_data,
  input  logic               retry_hit,
  input  logic               exhausted,
  input  logic               gap_done,
  output logic               clr,
  output logic               bump,
  output logic               tick_en,
  input  logic               cpl_err
);
  cfgrr_state_t state, nxt;
  logic [BUS_W-1:0] cur_bus;
  logic             take_cpl;

  assign req_ready   = (state == ST_IDLE);
  assign bdf_valid   = (state == ST_BDF);
  assign flush_valid = (state == ST_FLUSH);
  assign rd_valid    = (state == ST_RD);
  assign rsp_valid   = (state == ST_RSP);
  assign done        = rsp_valid && rsp_ready;
  assign bdf_value   = {cur_bus, cur_devfn};
  assign rd_dwaddr   = cur_offset[OFF_W-1:2];

  assign take_cpl = (state == ST_WAIT) && cpl_valid;
  assign clr      = req_valid && req_ready;
  assign bump     = take_cpl && retry_hit && !exhausted;
  assign tick_en  = (state == ST_GAP) && ms_tick;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req_valid)   nxt = ST_BDF;
      ST_BDF:   if (bdf_ready)   nxt = ST_FLUSH;
      ST_FLUSH: if (flush_ready) nxt = ST_RD;
      ST_RD:    if (rd_ready)    nxt = ST_WAIT;
      ST_WAIT:  if (cpl_valid)   nxt = (retry_hit && !exhausted) ? ST_GAP : ST_RSP;
      ST_GAP:   if (gap_done)    nxt = ST_BDF;
      ST_RSP:   if (rsp_ready)   nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bus    <= '0;
      cur_devfn  <= '0;
      cur_offset <= '0;
    end else if (clr) begin
      cur_bus    <= req_bus;
      cur_devfn  <= req_devfn;
      cur_offset <= req_offset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data      <= '0;
      rsp_not_found <= 1'b0;
    end else if (take_cpl && !bump) begin
      rsp_data      <= retry_hit ? ALL_ONES : eff_data;
      rsp_not_found <= retry_hit;   // only reached when the budget is spent
    end
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_not_found));
  a_r9_bdf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bdf_valid && !bdf_ready |=> bdf_valid && $stable(bdf_value));
  a_r5_flush_follows_bdf: assert property (@(posedge clk) disable iff (!rst_n)
    bdf_valid && bdf_ready |=> flush_valid);
  a_r5_read_follows_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_ready |=> rd_valid);
  a_r3_absent_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_not_found |-> rsp_data == ALL_ONES);
  a_r4_abort_gives_ones: assert property (@(posedge clk) disable iff (!rst_n)
    take_cpl && cpl_err |=> !rsp_valid || rsp_data == ALL_ONES);
  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bdf_valid && !flush_valid && !rd_valid && !rsp_valid);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/cfg_probe_retry.sv
module cfg_probe_retry
  import cfgrr_pkg::*;
#(
  parameter int MAX_RETRY = 1000,
  parameter int GAP_TICKS = 1,
  parameter int BUS_W     = 8,
  parameter int FN_W      = 8,
  parameter int OFF_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ms_tick,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BUS_W-1:0]      req_bus,
  input  logic [FN_W-1:0]       req_devfn,
  input  logic [OFF_W-1:0]      req_offset,
  output logic                  bdf_valid,
  input  logic                  bdf_ready,
  output logic [BUS_W+FN_W-1:0] bdf_value,
  output logic                  flush_valid,
  input  logic                  flush_ready,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [OFF_W-3:0]      rd_dwaddr,
  input  logic                  cpl_valid,
  input  logic [31:0]           cpl_data,
  input  logic                  cpl_err,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_data,
  output logic                  rsp_not_found,
  output logic                  done
);
  logic [FN_W-1:0]   cur_devfn;
  logic [OFF_W-1:0]  cur_offset;
  logic [DATA_W-1:0] eff_data;
  logic retry_hit, exhausted, gap_done, clr, bump, tick_en;

  cfgrr_qualify #(.OFF_W(OFF_W), .FN_W(FN_W)) u_qual (
    .offset(cur_offset), .devfn(cur_devfn), .raw_data(cpl_data), .raw_err(cpl_err),
    .eff_data(eff_data), .retry_hit(retry_hit)
  );

  cfgrr_pacer #(.MAX_RETRY(MAX_RETRY), .GAP_TICKS(GAP_TICKS)) u_pace (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bump(bump), .tick_en(tick_en),
    .exhausted(exhausted), .gap_done(gap_done)
  );

  cfgrr_seq #(.OFF_W(OFF_W), .FN_W(FN_W), .BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .bdf_valid(bdf_valid), .bdf_ready(bdf_ready), .bdf_value(bdf_value),
    .flush_valid(flush_valid), .flush_ready(flush_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_dwaddr(rd_dwaddr),
    .cpl_valid(cpl_valid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_not_found(rsp_not_found), .done(done),
    .cur_devfn(cur_devfn), .cur_offset(cur_offset),
    .eff_data(eff_data), .retry_hit(retry_hit), .exhausted(exhausted),
    .gap_done(gap_done), .clr(clr), .bump(bump), .tick_en(tick_en),
    .cpl_err(cpl_err)
  );

  initial begin
    if (MAX_RETRY < 0 || GAP_TICKS < 1) $error("bad retry parameters");
  end
endmodule

// File: tb/cfg_probe_retry_tb_top.sv
`timescale 1ns/1ps
module cfg_probe_retry_tb_top;
  localparam int MR = 4;
  localparam int GT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ms_tick = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [7:0] req_bus = '0, req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic bdf_valid, bdf_ready = 1'b0, flush_valid, flush_ready = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [15:0] bdf_value;
  logic [9:0] rd_dwaddr;
  logic cpl_valid = 1'b0, cpl_err = 1'b0;
  logic [31:0] cpl_data = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_not_found, done;
  logic [31:0] rsp_data;

  cfg_probe_retry #(.MAX_RETRY(MR), .GAP_TICKS(GT)) dut_i (.*);

  int checks = 0, fails = 0;
  int evq[$];
  logic [32:0] scr[$];
  logic [31:0] exp_data;
  logic exp_nf;
  logic [7:0] cur_bus, cur_devfn;
  logic [11:0] cur_off;
  int cyc = 0, cdown = 0, ticks = 0, attempts = 0;
  logic bdf_prev = 1'b0, hold_rsp = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  task automatic pop_ev(input int kind, input string rq);
    int got;
    got = (evq.size() != 0) ? evq.pop_front() : 0;
    chk(got == kind, rq, "handshake order", got, kind);
  endtask

  // Downstream model and per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bdf_ready   = (cyc % 3) != 0;
      flush_ready = (cyc % 2) == 0;
      rd_ready    = (cyc % 4) != 1;
      rsp_ready   = !hold_rsp && ((cyc % 3) != 2);
      ms_tick     = (cyc % 7) == 0;
      cpl_valid   = 1'b0;
      if (cdown > 0) begin
        cdown--;
        if (cdown == 0) begin
          if (scr.size() != 0) {cpl_err, cpl_data} = scr.pop_front();
          else {cpl_err, cpl_data} = 33'h0_DEADBEEF;
          cpl_valid = 1'b1;
          ticks = 0;
        end
      end
      #1;
      if (bdf_valid && !bdf_prev && attempts > 0)
        chk(ticks == GT, "R2", "ticks before retry", ticks, GT);
      bdf_prev = bdf_valid;
      if (bdf_valid && bdf_ready) begin
        pop_ev(1, "R5");
        chk(bdf_value == {cur_bus, cur_devfn}, "R5", "bdf_value", bdf_value, {cur_bus, cur_devfn});
      end
      if (flush_valid && flush_ready) pop_ev(2, "R5");
      if (rd_valid && rd_ready) begin
        pop_ev(3, "R5");
        chk(rd_dwaddr == cur_off[11:2], "R5", "rd_dwaddr", rd_dwaddr, cur_off[11:2]);
        attempts++;
        cdown = 3;
      end
      if (rsp_valid && rsp_ready) begin
        pop_ev(4, "R6");
        chk(rsp_data == exp_data, "R3/R4/R6", "rsp_data", rsp_data, exp_data);
        chk(rsp_not_found == exp_nf, "R3/R4", "rsp_not_found", rsp_not_found, exp_nf);
      end
      if (done || (rsp_valid && rsp_ready))
        chk(done == (rsp_valid && rsp_ready), "R7", "done pulse", done, rsp_valid && rsp_ready);
      if (ms_tick && !cpl_valid) ticks++;
    end
  end

  task automatic run_req(input logic [7:0] b, input logic [7:0] d, input logic [11:0] o);
    int n;
    logic [31:0] v;
    logic hit;
    n = 0;
    exp_nf = 1'b0;
    exp_data = '0;
    for (int i = 0; i < scr.size(); i++) begin
      v = scr[i][32] ? 32'hFFFF_FFFF : scr[i][31:0];
      hit = (o[11:2] == 10'd0) && (d == 8'd0) && (v == 32'd0 || v == 32'hFFFF_FFFF);
      n++;
      evq.push_back(1); evq.push_back(2); evq.push_back(3);
      if (!hit) begin exp_data = v; break; end
      if (n == MR + 1) begin exp_data = 32'hFFFF_FFFF; exp_nf = 1'b1; break; end
    end
    evq.push_back(4);
    cur_bus = b; cur_devfn = d; cur_off = o; attempts = 0;
    @(negedge clk);
    req_valid = 1'b1; req_bus = b; req_devfn = d; req_offset = o;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(!req_ready, "R7", "req_ready while busy", req_ready, 0);
    while (evq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(scr.size() == 0, "R3", "unused completions", scr.size(), 0);
  endtask

  task automatic main_seq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R7", "reset req_ready", req_ready, 1);
    chk(!bdf_valid && !rsp_valid && !rd_valid, "R9", "reset valids", {bdf_valid, rsp_valid, rd_valid}, 0);

    scr.push_back({1'b0, 32'h1234_10EC});                        // R6 good id first time
    run_req(8'h01, 8'h00, 12'h000);
    scr.push_back({1'b0, 32'h0}); scr.push_back({1'b0, 32'h0});  // R1 R2 two retries
    scr.push_back({1'b0, 32'hABCD_8086});
    run_req(8'h02, 8'h00, 12'h000);
    scr.push_back({1'b0, 32'h0});                                // R1 offset not id dword
    run_req(8'h03, 8'h00, 12'h004);
    scr.push_back({1'b0, 32'hFFFF_FFFF});                        // R1 low offset bits ignored
    scr.push_back({1'b0, 32'h5555_AAAA});
    run_req(8'h04, 8'h00, 12'h002);
    scr.push_back({1'b0, 32'h0});                                // R1 nonzero devfn
    run_req(8'h05, 8'h08, 12'h000);
    for (int i = 0; i <= MR; i++) scr.push_back({1'b0, 32'h0});  // R3 give up
    run_req(8'h06, 8'h00, 12'h000);
    scr.push_back({1'b1, 32'h1234_5678});                        // R4 abort, no retry
    run_req(8'h07, 8'h10, 12'h008);
    scr.push_back({1'b1, 32'h0}); scr.push_back({1'b0, 32'h0000_0001}); // R4 abort retried
    run_req(8'h08, 8'h00, 12'h000);
    for (int i = 0; i < MR; i++) scr.push_back({1'b0, 32'h0});   // R8 full budget again
    scr.push_back({1'b0, 32'h7777_1111});
    run_req(8'h09, 8'h00, 12'h000);
    hold_rsp = 1'b1;                                              // R9 back-pressure
    scr.push_back({1'b0, 32'hCAFE_0042});
    fork
      run_req(8'h0A, 8'h01, 12'h0FC);
      begin
        wait (rsp_valid);
        repeat (4) @(negedge clk);
        #1;
        chk(rsp_valid && rsp_data == 32'hCAFE_0042, "R9", "held response", rsp_data, 32'hCAFE_0042);
        hold_rsp = 1'b0;
      end
    join
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule